// File: doc/BRIEF.md
# Keyed Watermark Bit Sequence Generator

This block turns a 64-bit per-frame identity word into a serial stream of watermark bits, one bit for each quantized transform coefficient of a video frame. The identity word is built outside the block from fields such as the capture time, the date, a camera identifier and a frame serial number. Because of that, the stream differs from one frame to the next.

Two 32-bit secret keys control the stream. The first key seeds two 6-bit address counters. Each counter picks one bit of the stored identity word, and the two picked bits are XORed, which scrambles the word. The second key seeds a 32-bit LFSR. The LFSR output bit masks the scrambled bit.

A frame is started by a single-cycle start pulse. The embedder downstream then pulls bits one at a time through a request input. Each request yields one valid output bit on the next cycle. The 64-position pattern is swept repeatedly, CR times, so that the whole frame is covered. The last bit of the frame is flagged.

Top module: `wm_seq_gen`

## Requirements
- R1: After reset, `wm_valid_o` and `frame_done_o` are 0. Requests are ignored, producing no valid output, until the first `frame_start_i` pulse.
- R2: A `frame_start_i` pulse stores `prim_word_i` and loads the counters and the LFSR from `key1_i` and `key2_i`. Changes to these three inputs at any other time have no effect on the stream.
- R3: Bit k of a frame (k counted from 0) equals W[a_k] ^ W[b_k] ^ L_k. W is the stored word, with bit index 0 as the LSB. a_0 = key1[23:18] and b_0 = key1[10:5]. Both addresses increase by 1 modulo 64 after every output bit.
- R4: L_k is bit 31 of the LFSR state S_k. S_0 is key2. The next state is {S[30:0], S[31]^S[21]^S[1]^S[0]}, which is taps 32, 22, 2 and 1.
- R5: A key2 of all zeros is replaced by 32'h1 as the LFSR seed.
- R6: Each cycle in which `bit_req_i` is high during an active frame yields exactly one output bit with `wm_valid_o` high on the following cycle. A cycle without a request yields no valid output and does not advance the stream.
- R7: `frame_done_o` is high together with the valid output of bit number 64*CR-1 and at no other time. After that bit, requests are ignored until the next `frame_start_i`.
- R8: A `frame_start_i` in the middle of a frame restarts the frame. The word, both addresses, the LFSR and the bit count are all reloaded.
- R9: When `frame_start_i` and `bit_req_i` are high in the same cycle, the start takes effect and no bit is produced for that request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| frame_start_i | input | 1 | Start-of-frame pulse; latches the word and the keys |
| prim_word_i | input | 64 | Primitive per-frame identity word |
| key1_i | input | 32 | Scrambling key; seeds the address counters |
| key2_i | input | 32 | Masking key; seeds the LFSR |
| bit_req_i | input | 1 | Request for the next watermark bit |
| wm_bit_o | output | 1 | Watermark bit |
| wm_valid_o | output | 1 | `wm_bit_o` is valid this cycle |
| frame_done_o | output | 1 | Marks the last bit of the frame |

## Verification
The assertions assume that `bit_req_i` and `frame_start_i` are driven to known values from the end of reset onward. They also assume that every valid output traces back to a request seen on the previous cycle. The bench drives all inputs at the falling edge, so these conditions hold. It draws request gaps, keys and identity words from a seeded generator and adds directed cases: a zero key2, start and request in the same cycle, a restart in the middle of a frame, and requests past the end of a frame. A small CR keeps the number of full frames in the run reasonable.

// File: rtl/wm_seq_pkg.sv
package wm_seq_pkg;
  localparam int unsigned WORD_W  = 64;
  localparam int unsigned ADDR_W  = $clog2(WORD_W);
  localparam int unsigned KEY_W   = 32;
  localparam int unsigned N_ADDR  = 2;
  // key1 field offsets feeding the two address counters
  localparam int unsigned KEY1_A_LSB = 18;
  localparam int unsigned KEY1_B_LSB = 5;

  function automatic logic [KEY_W-1:0] lfsr_adv(input logic [KEY_W-1:0] s);
    logic fb;
    fb = s[31] ^ s[21] ^ s[1] ^ s[0];
    return {s[KEY_W-2:0], fb};
  endfunction
endpackage

// File: rtl/wm_addr_ctr.sv
module wm_addr_ctr #(
  parameter int unsigned W = 6
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] seed_i,
  input  logic         inc_i,
  output logic [W-1:0] addr_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     addr_o <= '0;
    else if (load_i) addr_o <= seed_i;
    else if (inc_i)  addr_o <= addr_o + W'(1);
  end

  assert_addr_step_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_i && !load_i) |=> addr_o == $past(addr_o) + W'(1));
  assert_addr_load_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> addr_o == $past(seed_i));
endmodule

// File: rtl/wm_lfsr.sv
module wm_lfsr
  import wm_seq_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [KEY_W-1:0] seed_i,
  input  logic             step_i,
  output logic             bit_o
);
  logic [KEY_W-1:0] st_q;
  logic [KEY_W-1:0] seed_fix;

  assign seed_fix = (seed_i == '0) ? KEY_W'(1) : seed_i;
  assign bit_o    = st_q[KEY_W-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     st_q <= KEY_W'(1);
    else if (load_i) st_q <= seed_fix;
    else if (step_i) st_q <= lfsr_adv(st_q);
  end

  assert_lfsr_nonzero_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_q != '0);
  assert_lfsr_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !step_i) |=> $stable(st_q));
endmodule

// File: rtl/wm_frame_ctr.sv
module wm_frame_ctr #(
  parameter int unsigned TOTAL = 65536
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clear_i,
  input  logic step_i,
  output logic last_o
);
  localparam int unsigned CW = $clog2(TOTAL + 1);
  logic [CW-1:0] cnt_q;

  assign last_o = (cnt_q == CW'(TOTAL - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (clear_i) cnt_q <= '0;
    else if (step_i)  cnt_q <= last_o ? '0 : cnt_q + CW'(1);
  end

  assert_cnt_bound_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q < CW'(TOTAL));
endmodule

// File: rtl/wm_seq_gen.sv
module wm_seq_gen
  import wm_seq_pkg::*;
#(
  parameter int unsigned CR = 1024
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              frame_start_i,
  input  logic [WORD_W-1:0] prim_word_i,
  input  logic [KEY_W-1:0]  key1_i,
  input  logic [KEY_W-1:0]  key2_i,
  input  logic              bit_req_i,
  output logic              wm_bit_o,
  output logic              wm_valid_o,
  output logic              frame_done_o
);
  localparam int unsigned FRAME_BITS = WORD_W * CR;

  logic [WORD_W-1:0] word_q;
  logic              active_q;
  logic              step;
  logic              last_bit;
  logic              mask_bit;
  logic              scr_bit;
  logic [ADDR_W-1:0] addr [N_ADDR];
  logic [ADDR_W-1:0] seed [N_ADDR];

  assign seed[0] = key1_i[KEY1_A_LSB +: ADDR_W];
  assign seed[1] = key1_i[KEY1_B_LSB +: ADDR_W];
  assign step    = bit_req_i && active_q && !frame_start_i;

  for (genvar g = 0; g < N_ADDR; g++) begin : g_addr
    wm_addr_ctr #(.W(ADDR_W)) u_ctr (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .load_i (frame_start_i),
      .seed_i (seed[g]),
      .inc_i  (step),
      .addr_o (addr[g])
    );
  end

  wm_lfsr u_lfsr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (frame_start_i),
    .seed_i (key2_i),
    .step_i (step),
    .bit_o  (mask_bit)
  );

  wm_frame_ctr #(.TOTAL(FRAME_BITS)) u_fcnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (frame_start_i),
    .step_i  (step),
    .last_o  (last_bit)
  );

  assign scr_bit = word_q[addr[0]] ^ word_q[addr[1]];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      word_q       <= '0;
      active_q     <= 1'b0;
      wm_bit_o     <= 1'b0;
      wm_valid_o   <= 1'b0;
      frame_done_o <= 1'b0;
    end else begin
      wm_valid_o   <= step;
      frame_done_o <= step && last_bit;
      if (step) wm_bit_o <= scr_bit ^ mask_bit;
      if (frame_start_i) begin
        word_q   <= prim_word_i;
        active_q <= 1'b1;
      end else if (step && last_bit) begin
        active_q <= 1'b0;
      end
    end
  end

  assert_valid_from_req_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wm_valid_o |-> $past(bit_req_i) && !$past(frame_start_i));
  assert_done_with_valid_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_done_o |-> wm_valid_o);
  assert_idle_after_done_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_done_o |=> !wm_valid_o);
  assert_start_no_bit_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_start_i |=> !wm_valid_o);
endmodule

// File: tb/tb_wm_seq_gen.sv
module tb_wm_seq_gen;
  localparam int unsigned CR    = 3;
  localparam int unsigned TOTAL = 64 * CR;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [63:0] word = '0;
  logic [31:0] k1 = '0;
  logic [31:0] k2 = '0;
  logic        req = 1'b0;
  logic        wbit, wvalid, wdone;

  int n_run = 0;
  int n_fail = 0;

  // bench model state
  logic [63:0] m_word;
  logic [5:0]  m_a, m_b;
  logic [31:0] m_l;
  int          m_cnt;
  bit          m_act = 0;

  always #5 clk = ~clk;

  wm_seq_gen #(.CR(CR)) dut (
    .clk_i(clk), .rst_ni(rst_n), .frame_start_i(start), .prim_word_i(word),
    .key1_i(k1), .key2_i(k2), .bit_req_i(req),
    .wm_bit_o(wbit), .wm_valid_o(wvalid), .frame_done_o(wdone)
  );

  function automatic logic [31:0] model_next(input logic [31:0] s);
    return {s[30:0], s[31] ^ s[21] ^ s[1] ^ s[0]};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_start(input logic [63:0] w, input logic [31:0] a, input logic [31:0] b,
                          input bit with_req);
    @(negedge clk);
    start = 1'b1; word = w; k1 = a; k2 = b; req = with_req;
    @(negedge clk);
    start = 1'b0; req = 1'b0;
    word = {$urandom, $urandom}; k1 = $urandom; k2 = $urandom;
    if (with_req) chk("R9 no bit on start+req", {31'd0, wvalid}, 32'd0);
    else          chk("R2 no bit on start", {31'd0, wvalid}, 32'd0);
    m_word = w; m_a = a[23:18]; m_b = a[10:5];
    m_l = (b == 32'd0) ? 32'd1 : b;
    m_cnt = 0; m_act = 1;
  endtask

  task automatic do_req(input string tag);
    logic eb; logic ed;
    @(negedge clk);
    req = 1'b1;
    @(negedge clk);
    req = 1'b0;
    if (m_act) begin
      eb = m_word[m_a] ^ m_word[m_b] ^ m_l[31];
      ed = (m_cnt == TOTAL - 1);
      chk({tag, " R6 valid"}, {31'd0, wvalid}, 32'd1);
      chk({tag, " R3 bit"}, {31'd0, wbit}, {31'd0, eb});
      chk({tag, " R7 done"}, {31'd0, wdone}, {31'd0, ed});
      m_a = m_a + 6'd1; m_b = m_b + 6'd1; m_l = model_next(m_l);
      m_cnt++;
      if (ed) m_act = 0;
    end else begin
      chk({tag, " R7 ignored req"}, {30'd0, wvalid, wdone}, 32'd0);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      chk("R6 no req no valid", {30'd0, wvalid, wdone}, 32'd0);
    end
  endtask

  task automatic run_bits(input int n, input string tag);
    for (int i = 0; i < n; i++) begin
      do_req(tag);
      if (($urandom % 4) == 0) idle($urandom % 3);
    end
  endtask

  initial begin
    #2_000_000;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk("R1 reset valid/done", {30'd0, wvalid, wdone}, 32'd0);
    rst_n = 1'b1;
    do_req("R1 pre-start");
    do_req("R1 pre-start");

    // directed: known keys, full frame, then requests past end
    do_start(64'h0123_4567_89AB_CDEF, 32'h00FC_07E0, 32'hDEAD_BEEF, 0);
    run_bits(TOTAL, "R3 R4 frame A");
    do_req("R7 past end");
    do_req("R7 past end");

    // zero key2
    do_start(64'hFFFF_0000_AAAA_5555, 32'h1234_5678, 32'h0, 0);
    run_bits(TOTAL, "R5 zero key2");

    // start and request in the same cycle, then mid-frame restart
    do_start({$urandom, $urandom}, $urandom, $urandom, 1);
    run_bits(37, "R9 after start+req");
    do_start({$urandom, $urandom}, $urandom, $urandom, 0);
    run_bits(TOTAL, "R8 restart");

    // random frames
    for (int f = 0; f < 6; f++) begin
      do_start({$urandom, $urandom}, $urandom, $urandom, 0);
      run_bits(TOTAL, "R2 random frame");
      do_req("R7 past end");
    end

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule